// File: doc/BRIEF.md
# Pipelined Four-Tap Constant-Coefficient FIR Filter

This block computes a four-tap finite impulse response y[m] = a0·x[m] + a1·x[m-1] + a2·x[m-2] + a3·x[m-3]. The four coefficients are fixed at elaboration and the arithmetic is two's complement. Registers sit only on cut-set edges, so no register-to-register path holds more than one constant multiplier or one adder. The output therefore equals the combinational filter's output delayed by a fixed number of clocks.

The parameter `ARCH` picks one of two arrangements. `ARCH_DIRECT` is a purely pipelined direct form with three cycles of latency. It has a three-deep sample delay line, registered products and a two-level registered adder tree. `ARCH_TRANSPOSED` regroups the additions into a registered accumulation chain and has one cycle of latency. Samples enter with a valid strobe, and the filter state moves only on strobed cycles. The full-precision result leaves with its own strobe.

Top module: `fir4_cutset`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0 and `y_o` is 0. All sample, product and sum registers clear asynchronously.
- R2: With `ARCH_DIRECT`, number the samples accepted since reset m = 0, 1, 2, and so on. In the cycle after sample m is accepted, `y_o` equals a0·x[m-2] + a1·x[m-3] + a2·x[m-4] + a3·x[m-5], with x of a negative index taken as 0. Under a continuous stream this is three clocks of latency.
- R3: With `ARCH_TRANSPOSED`, in the cycle after sample m is accepted, `y_o` equals a0·x[m] + a1·x[m-1] + a2·x[m-2] + a3·x[m-3]. This is one clock of latency.
- R4: `valid_o` is high only in the cycle right after a cycle with `valid_i` high. In direct form it is also held low for the first two accepted samples after reset. In transposed form it follows every accepted sample.
- R5: A cycle with `valid_i` low advances no register of the filter. `y_o` holds its value and `x_i` is ignored.
- R6: `y_o` is `DW+CW+2` bits wide and exact for every input, including runs of -2^(DW-1) and 2^(DW-1)-1.
- R7: An impulse (one sample of 1 followed by zeros) yields the outputs a0, a1, a2, a3 and then 0, in order, shifted by the latency.
- R8: A constant input c yields the partial sums c·a0, c·(a0+a1), c·(a0+a1+a2), and from the fourth sample on c·(a0+a1+a2+a3).
- R9: `COEF[i]` holds coefficient a_i as a signed CW-bit field. The defaults are a0=3, a1=-5, a2=7 and a3=-2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe; filter advances when high |
| x_i | input | DW | Signed input sample |
| valid_o | output | 1 | Result strobe |
| y_o | output | DW+CW+2 | Signed full-precision result |

## Verification
The assertions check these properties on every cycle:
- Reset clears both outputs.
- `valid_o` is only ever raised after a strobed input.
- `y_o` stays frozen on unstrobed cycles.
- `y_o` never leaves the magnitude bound set by the sum of absolute coefficient values.

Only the bench's scenarios can show the latency of each arrangement, the exact convolution values, the fill suppression of `valid_o` after reset, and the impulse and step responses. For these it runs both arrangements side by side against a behavioural convolution over the accepted-sample history.

// File: rtl/fir4_pkg.sv
package fir4_pkg;
  localparam int NTAPS = 4;

  typedef enum logic {
    ARCH_DIRECT     = 1'b0,
    ARCH_TRANSPOSED = 1'b1
  } fir_arch_e;
endpackage

// File: rtl/fir4_prod_reg.sv
// One registered constant multiply, full product width.
module fir4_prod_reg #(
  parameter int DW = 8,
  parameter int CW = 8,
  parameter logic [CW-1:0] COEF = '0,
  localparam int PW = DW + CW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic signed [DW-1:0] x_i,
  output logic signed [PW-1:0] p_o
);
  logic signed [PW-1:0] x_ext, c_ext;

  assign x_ext = PW'(x_i);
  assign c_ext = PW'($signed(COEF));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   p_o <= '0;
    else if (en_i) p_o <= x_ext * c_ext;
  end
endmodule

// File: rtl/fir4_direct.sv
// Purely pipelined direct form: delay line -> product regs -> pair sums -> output reg.
module fir4_direct
  import fir4_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 8,
  parameter logic [NTAPS-1:0][CW-1:0] COEF = '0,
  localparam int PW = DW + CW,
  localparam int SW = PW + 1,
  localparam int OW = PW + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic signed [DW-1:0] x_i,
  output logic signed [OW-1:0] y_o
);
  logic signed [DW-1:0] dly_q [1:NTAPS-1];
  logic signed [DW-1:0] tap_c [NTAPS];
  logic signed [PW-1:0] prod_w [NTAPS];
  logic signed [SW-1:0] pair_q [2];

  assign tap_c[0] = x_i;
  for (genvar i = 1; i < NTAPS; i++) begin : g_tap
    assign tap_c[i] = dly_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 1; k < NTAPS; k++) dly_q[k] <= '0;
    end else if (en_i) begin
      dly_q[1] <= x_i;
      for (int k = 2; k < NTAPS; k++) dly_q[k] <= dly_q[k-1];
    end
  end

  for (genvar i = 0; i < NTAPS; i++) begin : g_mul
    fir4_prod_reg #(.DW(DW), .CW(CW), .COEF(COEF[i])) u_prod (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (en_i),
      .x_i   (tap_c[i]),
      .p_o   (prod_w[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pair_q[0] <= '0;
      pair_q[1] <= '0;
      y_o       <= '0;
    end else if (en_i) begin
      pair_q[0] <= SW'(prod_w[0]) + SW'(prod_w[1]);
      pair_q[1] <= SW'(prod_w[2]) + SW'(prod_w[3]);
      y_o       <= OW'(pair_q[0]) + OW'(pair_q[1]);
    end
  end

  a_r5_tree_frozen : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(pair_q[0]) && $stable(pair_q[1]));
endmodule

// File: rtl/fir4_transposed.sv
// Transposed form: product regs feed a registered accumulation chain; final add drives the port.
module fir4_transposed
  import fir4_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 8,
  parameter logic [NTAPS-1:0][CW-1:0] COEF = '0,
  localparam int PW = DW + CW,
  localparam int OW = PW + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic signed [DW-1:0] x_i,
  output logic signed [OW-1:0] y_o
);
  logic signed [PW-1:0] prod_w [NTAPS];
  logic signed [OW-1:0] acc_q  [1:NTAPS-1];

  for (genvar i = 0; i < NTAPS; i++) begin : g_mul
    fir4_prod_reg #(.DW(DW), .CW(CW), .COEF(COEF[i])) u_prod (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (en_i),
      .x_i   (x_i),
      .p_o   (prod_w[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 1; k < NTAPS; k++) acc_q[k] <= '0;
    end else if (en_i) begin
      acc_q[NTAPS-1] <= OW'(prod_w[NTAPS-1]);
      for (int k = 1; k < NTAPS-1; k++) acc_q[k] <= OW'(prod_w[k]) + acc_q[k+1];
    end
  end

  assign y_o = OW'(prod_w[0]) + acc_q[1];

  a_r5_chain_frozen : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_q[1]));
endmodule

// File: rtl/fir4_valid.sv
// Output strobe: one cycle after an accepted sample, suppressed until the pipe has filled.
module fir4_valid #(
  parameter int LAT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic valid_o
);
  if (LAT > 1) begin : g_fill
    localparam int CNTW = $clog2(LAT);
    logic [CNTW-1:0] cnt_q;
    logic            full_c;

    assign full_c = (cnt_q == CNTW'(LAT - 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q   <= '0;
        valid_o <= 1'b0;
      end else begin
        if (valid_i && !full_c) cnt_q <= cnt_q + 1'b1;
        valid_o <= valid_i && full_c;
      end
    end
  end else begin : g_nofill
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) valid_o <= 1'b0;
      else         valid_o <= valid_i;
    end
  end

  a_r4_follows_input : assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i));
endmodule

// File: rtl/fir4_cutset.sv
module fir4_cutset
  import fir4_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 8,
  parameter logic [NTAPS-1:0][CW-1:0] COEF = {-8'sd2, 8'sd7, -8'sd5, 8'sd3},
  parameter fir_arch_e ARCH = ARCH_DIRECT,
  localparam int OW  = DW + CW + 2,
  localparam int LAT = (ARCH == ARCH_DIRECT) ? 3 : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [DW-1:0] x_i,
  output logic                 valid_o,
  output logic signed [OW-1:0] y_o
);
  if (ARCH == ARCH_DIRECT) begin : g_direct
    fir4_direct #(.DW(DW), .CW(CW), .COEF(COEF)) u_core (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (valid_i),
      .x_i   (x_i),
      .y_o   (y_o)
    );
  end else begin : g_transposed
    fir4_transposed #(.DW(DW), .CW(CW), .COEF(COEF)) u_core (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (valid_i),
      .x_i   (x_i),
      .y_o   (y_o)
    );
  end

  fir4_valid #(.LAT(LAT)) u_valid (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .valid_o(valid_o)
  );

  function automatic longint out_bound();
    longint s = 0;
    for (int i = 0; i < NTAPS; i++) begin
      longint c = longint'($signed(COEF[i]));
      s += (c < 0) ? -c : c;
    end
    return s * (longint'(1) <<< (DW - 1));
  endfunction

  localparam longint BOUND = out_bound();

  a_r1_reset_clear : assert property (@(posedge clk_i)
    !rst_ni |-> !valid_o && (y_o == '0));

  a_r5_hold_output : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(y_o));

  a_r6_in_range : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (longint'(y_o) <= BOUND) && (longint'(y_o) >= -BOUND));
endmodule

// File: tb/fir4_cutset_tb.sv
module fir4_cutset_tb;
  import fir4_pkg::*;

  localparam int DW = 8;
  localparam int CW = 8;
  localparam int OW = DW + CW + 2;
  localparam logic [NTAPS-1:0][CW-1:0] COEF_P = {-8'sd2, 8'sd7, -8'sd5, 8'sd3};
  // R9: a_i in COEF[i]; bench keeps its own copy
  int a [4] = '{3, -5, 7, -2};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_in = 1'b0;
  logic signed [DW-1:0] x_in = '0;
  logic valid_d, valid_t;
  logic signed [OW-1:0] y_d, y_t;

  always #10ns clk = ~clk;

  fir4_cutset #(.DW(DW), .CW(CW), .COEF(COEF_P), .ARCH(ARCH_DIRECT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_in), .x_i(x_in),
    .valid_o(valid_d), .y_o(y_d));

  fir4_cutset #(.DW(DW), .CW(CW), .COEF(COEF_P), .ARCH(ARCH_TRANSPOSED)) u_dut_tr (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_in), .x_i(x_in),
    .valid_o(valid_t), .y_o(y_t));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int xs[$];
  bit prev_v = 1'b0;
  string phase = "R1 reset";

  function automatic int yref(int j);
    int s = 0;
    for (int i = 0; i < 4; i++)
      if (j - i >= 0 && j - i < xs.size()) s += a[i] * xs[j-i];
    return s;
  endfunction

  task automatic chk(string who, logic v, logic signed [OW-1:0] y, int lat);
    bit ev;
    int ey;
    ev = prev_v && (xs.size() >= lat);
    ey = yref(xs.size() - lat);
    n_chk++;
    if (v !== ev) begin
      n_fail++;
      $display("FAIL R4 valid (%s, %s): got %0b expected %0b", phase, who, v, ev);
    end
    n_chk++;
    if (int'(y) != ey) begin
      n_fail++;
      $display("FAIL %s (%s): y got %0d expected %0d", phase, who, int'(y), ey);
    end
  endtask

  task automatic step(bit v, int x);
    chk("direct", valid_d, y_d, 3);     // R2
    chk("transposed", valid_t, y_t, 1); // R3
    valid_in = v;
    x_in = DW'(x);
    prev_v = v;
    if (v) xs.push_back(x);
    @(negedge clk);
  endtask

  task automatic reset_check();
    n_chk++;
    if (valid_d !== 1'b0 || valid_t !== 1'b0 || y_d !== '0 || y_t !== '0) begin
      n_fail++;
      $display("FAIL R1 reset: valid %0b/%0b y %0d/%0d expected 0", valid_d, valid_t,
               int'(y_d), int'(y_t));
    end
  endtask

  initial begin
    // R1: strobed input during reset must not leak
    valid_in = 1'b1;
    x_in = 8'sd55;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      reset_check();
    end
    valid_in = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    reset_check();

    // R7 impulse
    phase = "R7 impulse";
    step(1, 1);
    for (int i = 0; i < 7; i++) step(1, 0);

    // R8 step of constant 9
    phase = "R8 step";
    for (int i = 0; i < 10; i++) step(1, 9);

    // R5 stalls: x changes while valid low must be ignored
    phase = "R5 stall";
    for (int i = 0; i < 20; i++) begin
      step(1, i * 7 - 60);
      step(0, 127);
      step(0, -128);
    end

    // R2 R3 random stream with random gaps
    phase = "R2 R3 random";
    for (int i = 0; i < 400; i++) begin
      bit v = ($urandom_range(0, 9) < 7);
      step(v, $urandom_range(0, 255) - 128);
    end

    // R6 extreme magnitudes
    phase = "R6 extremes";
    for (int i = 0; i < 12; i++) step(1, -128);
    for (int i = 0; i < 12; i++) step(1, 127);
    for (int i = 0; i < 24; i++) step(1, (i % 2 == 0) ? -128 : 127);
    for (int i = 0; i < 24; i++) step(1, (i % 3 == 0) ? 127 : -128);
    step(0, 0);
    step(0, 0);

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(20ns * 50000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule